// File: doc/BRIEF.md
# Execution Priority Mask Unit

This block works out the priority level at which a processor core is currently running, and it decides which candidate exception requests are strong enough to break in. It holds three masking controls: a one-bit "block all" mask, a one-bit "block faults too" mask and an 8-bit priority threshold. It combines them with the priority of the exception currently being serviced. Lower numbers mean more urgent. The result is a signed effective level, and a candidate request passes only when its own level is strictly below that effective level.

The threshold has two write ports. The plain port loads any value. The raise-only port changes the threshold only when the new value tightens the masking. Privilege is modelled as a single write-enable input that gates every register write. When an exception handler returns, the fault mask is cleared automatically.

The effective level is carried as a signed value two bits wider than a priority field. Thread level, with no handler active, is encoded as 2^PRIO_W (256 by default). The fault mask gives -1. The hard-fault class sits at a fixed level of -1 and the non-maskable class at a fixed level of -2.

Top module: `exec_prio_mask`

## Requirements
- R1: After reset the block-all mask and the fault mask are 0 and the threshold is 0. With no active exception, `eff_prio` is then 256, the thread level.
- R2: With neither mask set, `eff_prio` is the smaller of two values: the active exception level (256 when `active_valid` is 0) and the threshold, where the threshold is counted only when it is nonzero.
- R3: While the block-all mask is 1, `eff_prio` is at most 0. Every maskable request is then blocked, while hard-fault and non-maskable requests still pass.
- R4: While the fault mask is 1, `eff_prio` is -1, encoded as all ones in 10 bits. Hard-fault requests are then blocked as well, and only non-maskable requests pass.
- R5: A nonzero threshold T blocks every maskable request with level greater than or equal to T. For example, 0x60 blocks 0x60 through 0xFF. A threshold of 0 masks nothing.
- R6: A plain threshold write loads any value in the next cycle, including a lower value or 0.
- R7: A raise-only write loads its value only when the value is nonzero and either the current threshold is 0 or the value is smaller than the current threshold. Otherwise the threshold is left unchanged. For example, with 0x60 held, 0xF0 is ignored and 0x40 is taken.
- R8: When plain and raise-only writes arrive in the same cycle, the plain write wins.
- R9: An exception-exit pulse clears the fault mask in the next cycle. It overrides a fault-mask write made in the same cycle.
- R10: While `wr_ok` is 0, writes to all three mask registers are ignored.
- R11: A request passes only when it is valid and its level is strictly below `eff_prio`. Hard-fault requests use a fixed level of -1 and non-maskable requests a fixed level of -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ok | input | 1 | Privilege: all register writes are allowed only while this is 1 |
| dis_we | input | 1 | Write strobe for the block-all mask |
| dis_val | input | 1 | Value for the block-all mask |
| flt_we | input | 1 | Write strobe for the fault mask |
| flt_val | input | 1 | Value for the fault mask |
| thr_we | input | 1 | Plain threshold write strobe |
| thr_val | input | PRIO_W | Plain threshold value |
| thr_raise_we | input | 1 | Raise-only threshold write strobe |
| thr_raise_val | input | PRIO_W | Raise-only threshold value |
| exc_exit | input | 1 | Exception handler return pulse |
| active_valid | input | 1 | An exception handler is active |
| active_lvl | input | PRIO_W | Priority of the active handler |
| req_valid | input | NUM_REQ | Candidate request valid bits |
| req_lvl | input | NUM_REQ*PRIO_W | Candidate levels, request i in bits [i*PRIO_W +: PRIO_W] |
| hf_req | input | 1 | Hard-fault request |
| nmi_req | input | 1 | Non-maskable request |
| eff_prio | output | PRIO_W+2 | Signed effective execution priority |
| req_pass | output | NUM_REQ | Per-request mask decision |
| hf_pass | output | 1 | Hard-fault request passes |
| nmi_pass | output | 1 | Non-maskable request passes |
| dis_q | output | 1 | Current block-all mask |
| flt_q | output | 1 | Current fault mask |
| thr_q | output | PRIO_W | Current threshold |

## Verification
A wrong mask register appears the cycle after the write that set it, both on its own state output and in `eff_prio`. A raise-only comparison in the wrong direction leaves the threshold too high or too low after a single write, so one read of `thr_q` exposes it. An off-by-one in the pass comparison shows up only at the exact boundary levels. The bench therefore sweeps every request level against several fixed mask states and active levels, and compares each decision in the same cycle as the inputs.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Fixed levels of the two classes that sit above all programmable levels
  localparam int PM_HF_LVL  = -1;
  localparam int PM_NMI_LVL = -2;

  function automatic int pm_min(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Raise-only rule: nonzero and tighter than (or replacing an absent) threshold
  function automatic bit pm_raise_ok(input int cur, input int nv);
    return (nv != 0) && ((cur == 0) || (nv < cur));
  endfunction

  // Effective level from the active level, the threshold and the two masks
  function automatic int pm_eff(input bit act_v, input int act, input int thr,
                                input bit dis, input bit flt, input int thread_lvl);
    int e;
    e = act_v ? act : thread_lvl;
    if (thr != 0) e = pm_min(e, thr);
    if (dis)      e = pm_min(e, 0);
    if (flt)      e = pm_min(e, PM_HF_LVL);
    return e;
  endfunction

endpackage

// File: rtl/pm_mask_regs.sv
module pm_mask_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              dis_we,
  input  logic              dis_val,
  input  logic              flt_we,
  input  logic              flt_val,
  input  logic              thr_we,
  input  logic [PRIO_W-1:0] thr_val,
  input  logic              thr_raise_we,
  input  logic [PRIO_W-1:0] thr_raise_val,
  input  logic              exc_exit,
  output logic              dis_q,
  output logic              flt_q,
  output logic [PRIO_W-1:0] thr_q,
  output logic              raise_taken
);
  import pm_pkg::*;

  logic plain_take;
  logic raise_try;

  assign plain_take  = wr_ok & thr_we;
  assign raise_try   = wr_ok & thr_raise_we & ~thr_we;
  assign raise_taken = raise_try & pm_raise_ok(int'(thr_q), int'(thr_raise_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      flt_q <= 1'b0;
      thr_q <= '0;
    end else begin
      if (wr_ok && dis_we) dis_q <= dis_val;
      if (exc_exit)                flt_q <= 1'b0;
      else if (wr_ok && flt_we)    flt_q <= flt_val;
      if (plain_take)       thr_q <= thr_val;
      else if (raise_taken) thr_q <= thr_raise_val;
    end
  end

  assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_exit |=> !flt_q);

  assert_raise_tightens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    raise_try |=> (thr_q == $past(thr_q)) ||
                  ((thr_q != 0) && (($past(thr_q) == 0) || (thr_q < $past(thr_q)))));

  assert_plain_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && thr_we && thr_raise_we) |=> (thr_q == $past(thr_val)));

  assert_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !exc_exit) |=> $stable({dis_q, flt_q, thr_q}));

endmodule

// File: rtl/pm_level_calc.sv
module pm_level_calc #(
  parameter int PRIO_W = 8,
  parameter int LVL_W  = PRIO_W + 2
) (
  input  logic                    active_valid,
  input  logic [PRIO_W-1:0]       active_lvl,
  input  logic                    dis_q,
  input  logic                    flt_q,
  input  logic [PRIO_W-1:0]       thr_q,
  output logic signed [LVL_W-1:0] eff_prio
);
  import pm_pkg::*;

  localparam int THREAD_LVL = 1 << PRIO_W;

  int eff_i;

  always_comb begin
    eff_i    = pm_eff(active_valid, int'(active_lvl), int'(thr_q), dis_q, flt_q, THREAD_LVL);
    eff_prio = LVL_W'(eff_i);
  end

endmodule

// File: rtl/pm_req_gate.sv
module pm_req_gate #(
  parameter int LVL_W = 10
) (
  input  logic                    valid,
  input  logic signed [LVL_W-1:0] lvl,
  input  logic signed [LVL_W-1:0] eff_prio,
  output logic                    pass
);
  assign pass = valid & (lvl < eff_prio);
endmodule

// File: rtl/exec_prio_mask.sv
module exec_prio_mask #(
  parameter int PRIO_W  = 8,
  parameter int NUM_REQ = 4,
  parameter int LVL_W   = PRIO_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_ok,
  input  logic                        dis_we,
  input  logic                        dis_val,
  input  logic                        flt_we,
  input  logic                        flt_val,
  input  logic                        thr_we,
  input  logic [PRIO_W-1:0]           thr_val,
  input  logic                        thr_raise_we,
  input  logic [PRIO_W-1:0]           thr_raise_val,
  input  logic                        exc_exit,
  input  logic                        active_valid,
  input  logic [PRIO_W-1:0]           active_lvl,
  input  logic [NUM_REQ-1:0]          req_valid,
  input  logic [NUM_REQ*PRIO_W-1:0]   req_lvl,
  input  logic                        hf_req,
  input  logic                        nmi_req,
  output logic signed [LVL_W-1:0]     eff_prio,
  output logic [NUM_REQ-1:0]          req_pass,
  output logic                        hf_pass,
  output logic                        nmi_pass,
  output logic                        dis_q,
  output logic                        flt_q,
  output logic [PRIO_W-1:0]           thr_q
);
  import pm_pkg::*;

  localparam int PAD_W = LVL_W - PRIO_W;
  localparam logic signed [LVL_W-1:0] HF_LVL  = LVL_W'(PM_HF_LVL);
  localparam logic signed [LVL_W-1:0] NMI_LVL = LVL_W'(PM_NMI_LVL);

  logic raise_taken;

  pm_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
    .dis_we(dis_we), .dis_val(dis_val),
    .flt_we(flt_we), .flt_val(flt_val),
    .thr_we(thr_we), .thr_val(thr_val),
    .thr_raise_we(thr_raise_we), .thr_raise_val(thr_raise_val),
    .exc_exit(exc_exit),
    .dis_q(dis_q), .flt_q(flt_q), .thr_q(thr_q),
    .raise_taken(raise_taken)
  );

  pm_level_calc #(.PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_calc (
    .active_valid(active_valid), .active_lvl(active_lvl),
    .dis_q(dis_q), .flt_q(flt_q), .thr_q(thr_q),
    .eff_prio(eff_prio)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic signed [LVL_W-1:0] lvl_s;
    assign lvl_s = $signed({{PAD_W{1'b0}}, req_lvl[i*PRIO_W +: PRIO_W]});
    pm_req_gate #(.LVL_W(LVL_W)) u_gate (
      .valid(req_valid[i]), .lvl(lvl_s), .eff_prio(eff_prio), .pass(req_pass[i])
    );
    assert_pass_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_pass[i] |-> req_valid[i]);
    assert_dis_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q |-> !req_pass[i]);
  end

  pm_req_gate #(.LVL_W(LVL_W)) u_hf_gate (
    .valid(hf_req), .lvl(HF_LVL), .eff_prio(eff_prio), .pass(hf_pass)
  );
  pm_req_gate #(.LVL_W(LVL_W)) u_nmi_gate (
    .valid(nmi_req), .lvl(NMI_LVL), .eff_prio(eff_prio), .pass(nmi_pass)
  );

  assert_dis_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> (eff_prio <= 0));
  assert_flt_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> (eff_prio == HF_LVL));
  assert_flt_blocks_hf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> !hf_pass);
  assert_below_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_valid |-> (eff_prio <= $signed({{PAD_W{1'b0}}, active_lvl})));
  assert_thr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != 0) |-> (eff_prio <= $signed({{PAD_W{1'b0}}, thr_q})));
  assert_raise_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    raise_taken |=> (thr_q != 0));

endmodule

// File: tb/exec_prio_mask_bench.sv
module exec_prio_mask_bench;
  localparam int PW = 8;
  localparam int NR = 2;
  localparam int LW = PW + 2;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_ok = 0, dis_we = 0, dis_val = 0, flt_we = 0, flt_val = 0;
  logic thr_we = 0, thr_raise_we = 0, exc_exit = 0;
  logic [PW-1:0] thr_val = '0, thr_raise_val = '0, active_lvl = '0;
  logic active_valid = 0, hf_req = 0, nmi_req = 0;
  logic [NR-1:0] req_valid = '0;
  logic [NR*PW-1:0] req_lvl = '0;
  logic signed [LW-1:0] eff_prio;
  logic [NR-1:0] req_pass;
  logic hf_pass, nmi_pass, dis_q, flt_q;
  logic [PW-1:0] thr_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exec_prio_mask #(.PRIO_W(PW), .NUM_REQ(NR)) u_exec_prio_mask (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
    .dis_we(dis_we), .dis_val(dis_val), .flt_we(flt_we), .flt_val(flt_val),
    .thr_we(thr_we), .thr_val(thr_val),
    .thr_raise_we(thr_raise_we), .thr_raise_val(thr_raise_val),
    .exc_exit(exc_exit), .active_valid(active_valid), .active_lvl(active_lvl),
    .req_valid(req_valid), .req_lvl(req_lvl), .hf_req(hf_req), .nmi_req(nmi_req),
    .eff_prio(eff_prio), .req_pass(req_pass), .hf_pass(hf_pass), .nmi_pass(nmi_pass),
    .dis_q(dis_q), .flt_q(flt_q), .thr_q(thr_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock of register writes; strobes are dropped at the following negedge
  task automatic wr(input bit ok, input bit dw, input bit dv, input bit fw, input bit fv,
                    input bit tw, input int tv, input bit rw, input int rv, input bit ex);
    @(negedge clk);
    wr_ok = ok; dis_we = dw; dis_val = dv; flt_we = fw; flt_val = fv;
    thr_we = tw; thr_val = PW'(tv); thr_raise_we = rw; thr_raise_val = PW'(rv);
    exc_exit = ex;
    @(negedge clk);
    wr_ok = 0; dis_we = 0; flt_we = 0; thr_we = 0; thr_raise_we = 0; exc_exit = 0;
    #2;
  endtask

  task automatic set_masks(input bit d, input bit f, input int t);
    wr(1, 1, d, 1, f, 1, t, 0, 0, 0);
  endtask

  function automatic int model_eff(input bit av, input int a, input bit d, input bit f, input int t);
    int e;
    if (f) return -1;
    if (d) return (av && a < 0) ? a : 0;
    e = av ? a : 256;
    if (t != 0 && t < e) e = t;
    return e;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cfg_d[8];
    int cfg_f[8];
    int cfg_t[8];
    int acts[5];
    cfg_d = '{0, 0, 0, 1, 1, 0, 0, 0};
    cfg_f = '{0, 0, 0, 0, 0, 1, 1, 0};
    cfg_t = '{0, 'h60, 'h01, 0, 'h80, 0, 'h40, 'hFF};
    acts  = '{-1, 0, 'h40, 'h80, 'hFF};

    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R1: reset state
    chk("R1 dis_q", int'(dis_q), 0);
    chk("R1 flt_q", int'(flt_q), 0);
    chk("R1 thr_q", int'(thr_q), 0);
    chk("R1 eff_prio", int'(eff_prio), 256);

    // Sweep: R2 R3 R4 R5 R11
    hf_req = 1; nmi_req = 1;
    for (int c = 0; c < 8; c++) begin
      set_masks(cfg_d[c][0], cfg_f[c][0], cfg_t[c]);
      chk("R6 thr_q after plain write", int'(thr_q), cfg_t[c]);
      for (int a = 0; a < 5; a++) begin
        active_valid = (acts[a] >= 0);
        active_lvl = PW'(acts[a] < 0 ? 0 : acts[a]);
        for (int l = 0; l < 256; l++) begin
          int e;
          int l1;
          bit v1;
          l1 = 255 - l;
          v1 = (l % 3) != 0;
          req_lvl = {PW'(l1), PW'(l)};
          req_valid = {v1, 1'b1};
          #1;
          e = model_eff(active_valid, acts[a], cfg_d[c][0], cfg_f[c][0], cfg_t[c]);
          if (l == 0) begin
            chk("R2 R3 R4 eff_prio", int'(eff_prio), e);
            chk("R4 hf_pass", int'(hf_pass), (e > -1) ? 1 : 0);
            chk("R11 nmi_pass", int'(nmi_pass), 1);
          end
          chk("R5 R11 req_pass0", int'(req_pass[0]), (l < e) ? 1 : 0);
          chk("R5 R11 req_pass1", int'(req_pass[1]), (v1 && l1 < e) ? 1 : 0);
        end
      end
    end
    active_valid = 0; req_valid = '0;

    // R7: raise-only rules
    set_masks(0, 0, 'h60);
    wr(1, 0, 0, 0, 0, 0, 0, 1, 'hF0, 0);
    chk("R7 raise to 0xF0 ignored", int'(thr_q), 'h60);
    wr(1, 0, 0, 0, 0, 0, 0, 1, 'h60, 0);
    chk("R7 equal raise ignored", int'(thr_q), 'h60);
    wr(1, 0, 0, 0, 0, 0, 0, 1, 'h40, 0);
    chk("R7 raise to 0x40 taken", int'(thr_q), 'h40);
    wr(1, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 raise to 0 ignored", int'(thr_q), 'h40);
    // R6: plain write may lower or clear
    wr(1, 0, 0, 0, 0, 1, 'hC0, 0, 0, 0);
    chk("R6 plain lowers mask", int'(thr_q), 'hC0);
    wr(1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6 plain clears", int'(thr_q), 0);
    chk("R5 thr 0 no masking eff", int'(eff_prio), 256);
    wr(1, 0, 0, 0, 0, 0, 0, 1, 'h80, 0);
    chk("R7 raise from 0 taken", int'(thr_q), 'h80);
    // R8: plain wins over raise-only
    wr(1, 0, 0, 0, 0, 1, 'h20, 1, 'h10, 0);
    chk("R8 plain wins", int'(thr_q), 'h20);
    // R10: writes without privilege are ignored
    wr(0, 1, 1, 1, 1, 1, 'h05, 1, 'h01, 0);
    chk("R10 thr unchanged", int'(thr_q), 'h20);
    chk("R10 dis unchanged", int'(dis_q), 0);
    chk("R10 flt unchanged", int'(flt_q), 0);
    chk("R10 eff unchanged", int'(eff_prio), 'h20);
    // R9: exit clears fault mask, and beats a simultaneous set
    set_masks(0, 1, 0);
    chk("R9 flt set", int'(flt_q), 1);
    wr(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 exit clears", int'(flt_q), 0);
    chk("R9 eff after exit", int'(eff_prio), 256);
    wr(1, 0, 0, 1, 1, 0, 0, 0, 0, 1);
    chk("R9 exit beats write", int'(flt_q), 0);
    // R3: block-all mask keeps its setting across an exit
    set_masks(1, 0, 0);
    wr(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R3 dis kept across exit", int'(dis_q), 1);
    chk("R3 hf passes", int'(hf_pass), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule